// File: doc/BRIEF.md
# Command Frame Controller

This block sits in the system clock domain behind a byte receiver whose output has already been synchronized. Each received byte arrives with a one-cycle valid strobe. The block reads the first byte of a frame as an opcode and collects the remaining bytes of that frame. It then drives a register file port or an arithmetic unit. Any result goes byte by byte into a transmit FIFO.

There are four frame types. A register write frame carries an address and a data byte. A register read frame carries an address, and the returned byte is queued for transmission. A full arithmetic frame carries two operands and a function code. The two operands are first stored at register addresses 0 and 1. A short arithmetic frame carries only a function code and reuses the operands already stored. For both arithmetic frames the block enables the arithmetic clock gate and the unit itself. It waits for the 16-bit result and then queues it as two bytes, low byte first.

Top module: `cmd_frame_ctrl`

## Requirements
- R1: While rst_ni is low, every output is 0.
- R2: Frame 0xAA, addr, data: in the cycle after the data byte is accepted, rf_wr_en_o is high for exactly one cycle. In that cycle rf_addr_o equals the low 4 bits of addr and rf_wdata_o equals data.
- R3: Frame 0xBB, addr: in the cycle after addr is accepted, rf_rd_en_o is high for one cycle with rf_addr_o equal to addr. The byte on rf_rdata_i when rf_rvalid_i is high is then written once into the FIFO.
- R4: Frame 0xCC, A, B, fun: A produces a one-cycle write to address 0 and B a one-cycle write to address 1. Each write comes in the cycle after its byte.
- R5: After the function byte of an arithmetic frame, alu_en_o and alu_clk_en_o are high from the next cycle. alu_fun_o equals the low 4 bits of that byte. Both enables stay high until alu_valid_i is seen and are low in the cycle after it.
- R6: Frame 0xDD, fun runs the arithmetic unit as in R5 without any register write.
- R7: An arithmetic result produces exactly two FIFO writes, bits 7:0 first, then bits 15:8.
- R8: fifo_wr_en_o is never high while fifo_full_i is high. A pending byte is held and written once full clears.
- R9: A first byte other than 0xAA, 0xBB, 0xCC or 0xDD produces no output activity. The next opcode is decoded normally.
- R10: Bytes that arrive while the block waits for a read or arithmetic result, or while it is pushing one, are dropped.
- R11: rx_data_i has no effect while rx_valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | One-cycle strobe for rx_data_i |
| rf_addr_o | output | 4 | Register file address |
| rf_wdata_o | output | 8 | Register file write data |
| rf_wr_en_o | output | 1 | Register write strobe |
| rf_rd_en_o | output | 1 | Register read strobe |
| rf_rdata_i | input | 8 | Register read data |
| rf_rvalid_i | input | 1 | Read data valid |
| alu_en_o | output | 1 | Arithmetic unit enable |
| alu_fun_o | output | 4 | Arithmetic function code |
| alu_res_i | input | 16 | Arithmetic result |
| alu_valid_i | input | 1 | Result valid |
| alu_clk_en_o | output | 1 | Clock-gate enable for the arithmetic clock |
| fifo_wdata_o | output | 8 | Byte to transmit FIFO |
| fifo_wr_en_o | output | 1 | FIFO write strobe |
| fifo_full_i | input | 1 | FIFO full |

## Verification
Register write and read strobes are registered and appear one cycle after the edge that accepts the byte. The enables for the arithmetic unit rise in that same following cycle and fall one cycle after the result-valid edge. The first FIFO byte follows a result by two cycles. After that the FIFO write depends only on the full input. The bench drives inputs one time unit after a rising edge and samples at the falling edge, where registered outputs have settled. A monitor logs every strobe at the falling edge. Each frame is then given a settling window of twenty cycles before its logs are compared. The cycle-exact relations are checked by properties in the checker.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam logic [7:0] OP_REG_WR  = 8'hAA;
  localparam logic [7:0] OP_REG_RD  = 8'hBB;
  localparam logic [7:0] OP_ALU_OPS = 8'hCC;
  localparam logic [7:0] OP_ALU_FUN = 8'hDD;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WR_ADDR,
    ST_WR_DATA,
    ST_RD_ADDR,
    ST_RD_WAIT,
    ST_OPA,
    ST_OPB,
    ST_FUN,
    ST_ALU_WAIT,
    ST_PUSH
  } state_e;
endpackage

// File: rtl/cfc_decoder.sv
module cfc_decoder
  import cfc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int FUN_W  = 4,
  parameter int ALU_W  = 16,
  localparam int RESP_BYTES = ALU_W / 8,
  localparam int CNT_W = $clog2(RESP_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  output logic [ADDR_W-1:0] rf_addr_o,
  output logic [7:0]        rf_wdata_o,
  output logic              rf_wr_en_o,
  output logic              rf_rd_en_o,
  input  logic [7:0]        rf_rdata_i,
  input  logic              rf_rvalid_i,
  output logic              alu_en_o,
  output logic [FUN_W-1:0]  alu_fun_o,
  input  logic [ALU_W-1:0]  alu_res_i,
  input  logic              alu_valid_i,
  output logic              alu_clk_en_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_cnt_o,
  output logic [ALU_W-1:0]  load_data_o,
  input  logic              push_busy_i
);
  state_e              state_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [7:0]          wdata_q;
  logic                wr_q, rd_q, load_q;
  logic [FUN_W-1:0]    fun_q;
  logic [CNT_W-1:0]    load_cnt_q;
  logic [ALU_W-1:0]    load_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      wdata_q     <= '0;
      wr_q        <= 1'b0;
      rd_q        <= 1'b0;
      load_q      <= 1'b0;
      fun_q       <= '0;
      load_cnt_q  <= '0;
      load_data_q <= '0;
    end else begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      load_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (rx_valid_i) begin
          unique case (rx_data_i)
            OP_REG_WR:  state_q <= ST_WR_ADDR;
            OP_REG_RD:  state_q <= ST_RD_ADDR;
            OP_ALU_OPS: state_q <= ST_OPA;
            OP_ALU_FUN: state_q <= ST_FUN;
            default:    state_q <= ST_IDLE; // unknown opcode dropped
          endcase
        end
        ST_WR_ADDR: if (rx_valid_i) begin
          addr_q  <= rx_data_i[ADDR_W-1:0];
          state_q <= ST_WR_DATA;
        end
        ST_WR_DATA: if (rx_valid_i) begin
          wdata_q <= rx_data_i;
          wr_q    <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_RD_ADDR: if (rx_valid_i) begin
          addr_q  <= rx_data_i[ADDR_W-1:0];
          rd_q    <= 1'b1;
          state_q <= ST_RD_WAIT;
        end
        ST_RD_WAIT: if (rf_rvalid_i) begin
          load_q      <= 1'b1;
          load_cnt_q  <= CNT_W'(1);
          load_data_q <= {{(ALU_W-8){1'b0}}, rf_rdata_i};
          state_q     <= ST_PUSH;
        end
        ST_OPA: if (rx_valid_i) begin
          addr_q  <= ADDR_W'(0);
          wdata_q <= rx_data_i;
          wr_q    <= 1'b1;
          state_q <= ST_OPB;
        end
        ST_OPB: if (rx_valid_i) begin
          addr_q  <= ADDR_W'(1);
          wdata_q <= rx_data_i;
          wr_q    <= 1'b1;
          state_q <= ST_FUN;
        end
        ST_FUN: if (rx_valid_i) begin
          fun_q   <= rx_data_i[FUN_W-1:0];
          state_q <= ST_ALU_WAIT;
        end
        ST_ALU_WAIT: if (alu_valid_i) begin
          load_q      <= 1'b1;
          load_cnt_q  <= CNT_W'(RESP_BYTES);
          load_data_q <= alu_res_i;
          state_q     <= ST_PUSH;
        end
        ST_PUSH: if (!load_q && !push_busy_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rf_addr_o    = addr_q;
  assign rf_wdata_o   = wdata_q;
  assign rf_wr_en_o   = wr_q;
  assign rf_rd_en_o   = rd_q;
  assign alu_en_o     = (state_q == ST_ALU_WAIT);
  assign alu_clk_en_o = (state_q == ST_ALU_WAIT);
  assign alu_fun_o    = fun_q;
  assign load_o       = load_q;
  assign load_cnt_o   = load_cnt_q;
  assign load_data_o  = load_data_q;
endmodule

// File: rtl/cfc_tx_push.sv
module cfc_tx_push #(
  parameter int ALU_W = 16,
  localparam int RESP_BYTES = ALU_W / 8,
  localparam int CNT_W = $clog2(RESP_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic [ALU_W-1:0] load_data_i,
  input  logic             fifo_full_i,
  output logic             busy_o,
  output logic [7:0]       fifo_wdata_o,
  output logic             fifo_wr_en_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [ALU_W-1:0] shift_q;
  logic             push;

  assign push = (cnt_q != '0) && !fifo_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (load_i) begin
      cnt_q   <= load_cnt_i;
      shift_q <= load_data_i;
    end else if (push) begin
      cnt_q   <= cnt_q - CNT_W'(1);
      shift_q <= shift_q >> 8;
    end
  end

  assign busy_o       = (cnt_q != '0);
  assign fifo_wr_en_o = push;
  assign fifo_wdata_o = push ? shift_q[7:0] : 8'h00;
endmodule

// File: rtl/cmd_frame_ctrl.sv
module cmd_frame_ctrl #(
  parameter int ADDR_W = 4,
  parameter int FUN_W  = 4,
  parameter int ALU_W  = 16,
  localparam int RESP_BYTES = ALU_W / 8,
  localparam int CNT_W = $clog2(RESP_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  output logic [ADDR_W-1:0] rf_addr_o,
  output logic [7:0]        rf_wdata_o,
  output logic              rf_wr_en_o,
  output logic              rf_rd_en_o,
  input  logic [7:0]        rf_rdata_i,
  input  logic              rf_rvalid_i,
  output logic              alu_en_o,
  output logic [FUN_W-1:0]  alu_fun_o,
  input  logic [ALU_W-1:0]  alu_res_i,
  input  logic              alu_valid_i,
  output logic              alu_clk_en_o,
  output logic [7:0]        fifo_wdata_o,
  output logic              fifo_wr_en_o,
  input  logic              fifo_full_i
);
  logic             load;
  logic [CNT_W-1:0] load_cnt;
  logic [ALU_W-1:0] load_data;
  logic             push_busy;

  cfc_decoder #(.ADDR_W(ADDR_W), .FUN_W(FUN_W), .ALU_W(ALU_W)) u_dec (
    .clk_i, .rst_ni, .rx_data_i, .rx_valid_i,
    .rf_addr_o, .rf_wdata_o, .rf_wr_en_o, .rf_rd_en_o, .rf_rdata_i, .rf_rvalid_i,
    .alu_en_o, .alu_fun_o, .alu_res_i, .alu_valid_i, .alu_clk_en_o,
    .load_o(load), .load_cnt_o(load_cnt), .load_data_o(load_data),
    .push_busy_i(push_busy)
  );

  cfc_tx_push #(.ALU_W(ALU_W)) u_push (
    .clk_i, .rst_ni,
    .load_i(load), .load_cnt_i(load_cnt), .load_data_i(load_data),
    .fifo_full_i, .busy_o(push_busy),
    .fifo_wdata_o, .fifo_wr_en_o
  );
endmodule

// File: rtl/cfc_checker.sv
module cfc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_valid_i,
  input logic rf_wr_en_o,
  input logic rf_rd_en_o,
  input logic alu_en_o,
  input logic alu_valid_i,
  input logic alu_clk_en_o,
  input logic fifo_wr_en_o,
  input logic fifo_full_i
);
  assert_wr_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_wr_en_o |=> !rf_wr_en_o);
  assert_wr_after_byte_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_wr_en_o |-> $past(rx_valid_i));
  assert_rd_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_rd_en_o |=> !rf_rd_en_o);
  assert_rd_after_byte_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_rd_en_o |-> $past(rx_valid_i));
  assert_alu_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alu_en_o) |-> $past(rx_valid_i));
  assert_gate_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_clk_en_o && alu_valid_i) |=> !alu_clk_en_o);
  assert_no_push_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_i |-> !fifo_wr_en_o);
  assert_rd_wr_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rf_wr_en_o && rf_rd_en_o));
endmodule

bind cmd_frame_ctrl cfc_checker u_chk (
  .clk_i, .rst_ni, .rx_valid_i, .rf_wr_en_o, .rf_rd_en_o,
  .alu_en_o, .alu_valid_i, .alu_clk_en_o, .fifo_wr_en_o, .fifo_full_i
);

// File: tb/tb_cmd_frame_ctrl.sv
module tb_cmd_frame_ctrl;
  typedef struct packed {
    logic [7:0]  b0, b1, b2, b3;
    logic [2:0]  n;
    logic [15:0] res;
    logic [1:0]  nwr;
    logic [3:0]  wa;
    logic [7:0]  wd;
    logic [1:0]  np;
    logic [7:0]  p0, p1;
    logic        alu;
    logic [3:0]  fun;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{8'hAA,8'h05,8'h3C,8'h00,3'd3,16'h0000,2'd1,4'h5,8'h3C,2'd0,8'h00,8'h00,1'b0,4'h0},
    '{8'hBB,8'h05,8'h00,8'h00,3'd2,16'h0000,2'd0,4'h0,8'h00,2'd1,8'h3C,8'h00,1'b0,4'h0},
    '{8'hCC,8'h12,8'h34,8'h02,3'd4,16'hBEEF,2'd2,4'h1,8'h34,2'd2,8'hEF,8'hBE,1'b1,4'h2},
    '{8'hBB,8'h00,8'h00,8'h00,3'd2,16'h0000,2'd0,4'h0,8'h00,2'd1,8'h12,8'h00,1'b0,4'h0},
    '{8'hDD,8'h07,8'h00,8'h00,3'd2,16'h0A55,2'd0,4'h0,8'h00,2'd2,8'h55,8'h0A,1'b1,4'h7},
    '{8'h5A,8'h00,8'h00,8'h00,3'd1,16'h0000,2'd0,4'h0,8'h00,2'd0,8'h00,8'h00,1'b0,4'h0},
    '{8'hAA,8'h0F,8'h99,8'h00,3'd3,16'h0000,2'd1,4'hF,8'h99,2'd0,8'h00,8'h00,1'b0,4'h0},
    '{8'hBB,8'h0F,8'h00,8'h00,3'd2,16'h0000,2'd0,4'h0,8'h00,2'd1,8'h99,8'h00,1'b0,4'h0},
    '{8'hBB,8'h01,8'h00,8'h00,3'd2,16'h0000,2'd0,4'h0,8'h00,2'd1,8'h34,8'h00,1'b0,4'h0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_valid_i = 1'b0;
  logic [3:0]  rf_addr_o;
  logic [7:0]  rf_wdata_o;
  logic        rf_wr_en_o, rf_rd_en_o;
  logic [7:0]  rf_rdata_i = '0;
  logic        rf_rvalid_i = 1'b0;
  logic        alu_en_o;
  logic [3:0]  alu_fun_o;
  logic [15:0] alu_res_i = '0;
  logic        alu_valid_i = 1'b0;
  logic        alu_clk_en_o;
  logic [7:0]  fifo_wdata_o;
  logic        fifo_wr_en_o;
  logic        fifo_full_i = 1'b0;

  always #2 clk = ~clk;

  cmd_frame_ctrl dut (
    .clk_i(clk), .rst_ni, .rx_data_i, .rx_valid_i,
    .rf_addr_o, .rf_wdata_o, .rf_wr_en_o, .rf_rd_en_o, .rf_rdata_i, .rf_rvalid_i,
    .alu_en_o, .alu_fun_o, .alu_res_i, .alu_valid_i, .alu_clk_en_o,
    .fifo_wdata_o, .fifo_wr_en_o, .fifo_full_i
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] mem [16];
  logic [7:0] push_log [64];
  int push_n = 0, wr_n = 0;
  logic [3:0] last_wa = '0;
  logic [7:0] last_wd = '0;
  logic [3:0] last_fun = '0;
  logic [15:0] cur_res = '0;
  int alu_lat = 3, alu_cnt = 0;

  initial for (int k = 0; k < 16; k++) mem[k] = '0;

  // monitor
  always @(negedge clk) begin
    if (rst_ni && fifo_wr_en_o) begin
      if (push_n < 64) push_log[push_n] = fifo_wdata_o;
      push_n++;
    end
    if (rst_ni && rf_wr_en_o) begin
      wr_n++;
      last_wa = rf_addr_o;
      last_wd = rf_wdata_o;
      mem[rf_addr_o] = rf_wdata_o;
    end
    if (rst_ni && alu_en_o) last_fun = alu_fun_o;
  end

  // register file responder
  always @(posedge clk) begin
    #1;
    if (rf_rd_en_o) begin
      rf_rvalid_i = 1'b1;
      rf_rdata_i  = mem[rf_addr_o];
    end else rf_rvalid_i = 1'b0;
  end

  // arithmetic responder
  always @(posedge clk) begin
    #1;
    if (alu_en_o && !alu_valid_i) begin
      if (alu_cnt >= alu_lat) begin
        alu_valid_i = 1'b1;
        alu_res_i   = cur_res;
        alu_cnt     = 0;
      end else alu_cnt++;
    end else alu_valid_i = 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(posedge clk); #1;
    rx_data_i  = b;
    rx_valid_i = 1'b1;
    @(posedge clk); #1;
    rx_valid_i = 1'b0;
  endtask

  task automatic settle(input int c);
    repeat (c) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      summary();
    end
  end

  initial begin
    int bp, bw;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({rf_wr_en_o, rf_rd_en_o, alu_en_o, alu_clk_en_o, fifo_wr_en_o} == 5'b0,
        "R1 strobes in reset", {rf_wr_en_o, rf_rd_en_o, alu_en_o, alu_clk_en_o, fifo_wr_en_o}, 0);
    chk({rf_addr_o, rf_wdata_o, alu_fun_o, fifo_wdata_o} == '0,
        "R1 data in reset", {rf_addr_o, rf_wdata_o, alu_fun_o, fifo_wdata_o}, 0);
    @(posedge clk); #1 rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      bp = push_n; bw = wr_n;
      cur_res = TBL[i].res;
      send(TBL[i].b0);
      if (TBL[i].n > 1) send(TBL[i].b1);
      if (TBL[i].n > 2) send(TBL[i].b2);
      if (TBL[i].n > 3) send(TBL[i].b3);
      settle(20);
      // R2 R4 R6 R9: register writes
      chk(wr_n - bw == int'(TBL[i].nwr), $sformatf("R2/R4/R6/R9 vec%0d write count", i), wr_n - bw, TBL[i].nwr);
      if (TBL[i].nwr != 0)
        chk({last_wa, last_wd} == {TBL[i].wa, TBL[i].wd}, $sformatf("R2/R4 vec%0d write addr,data", i),
            {last_wa, last_wd}, {TBL[i].wa, TBL[i].wd});
      // R3 R7 R9: FIFO bytes
      chk(push_n - bp == int'(TBL[i].np), $sformatf("R3/R7/R9 vec%0d push count", i), push_n - bp, TBL[i].np);
      if (TBL[i].np > 0 && push_n - bp >= 1)
        chk(push_log[bp] == TBL[i].p0, $sformatf("R3/R7 vec%0d byte0", i), push_log[bp], TBL[i].p0);
      if (TBL[i].np > 1 && push_n - bp >= 2)
        chk(push_log[bp+1] == TBL[i].p1, $sformatf("R7 vec%0d byte1", i), push_log[bp+1], TBL[i].p1);
      if (TBL[i].alu) begin
        chk(last_fun == TBL[i].fun, $sformatf("R5 vec%0d function", i), last_fun, TBL[i].fun);
        chk(!alu_clk_en_o && !alu_en_o, $sformatf("R5 vec%0d gate off", i), alu_clk_en_o, 0);
      end
    end

    // R11: data without valid ignored; a following read must decode as read
    bp = push_n;
    @(posedge clk); #1 rx_data_i = 8'hAA;
    repeat (5) @(posedge clk);
    send(8'hBB); send(8'h0F);
    settle(20);
    chk(push_n - bp == 1, "R11 push count", push_n - bp, 1);
    if (push_n - bp >= 1) chk(push_log[bp] == 8'h99, "R11 byte", push_log[bp], 8'h99);

    // R8: full holds the byte
    bp = push_n;
    @(posedge clk); #1 fifo_full_i = 1'b1;
    send(8'hBB); send(8'h05);
    settle(10);
    chk(push_n - bp == 0, "R8 no push while full", push_n - bp, 0);
    @(posedge clk); #1 fifo_full_i = 1'b0;
    settle(10);
    chk(push_n - bp == 1, "R8 push after full clears", push_n - bp, 1);
    if (push_n - bp >= 1) chk(push_log[bp] == 8'h3C, "R8 held byte", push_log[bp], 8'h3C);

    // R10 R5 R6: bytes during ALU wait are dropped
    bp = push_n; bw = wr_n;
    alu_lat = 12; cur_res = 16'hC3A5;
    send(8'hDD); send(8'h03);
    @(negedge clk);
    chk(alu_en_o && alu_clk_en_o, "R5 enables high after function byte", {alu_en_o, alu_clk_en_o}, 2'b11);
    chk(alu_fun_o == 4'h3, "R5 function code", alu_fun_o, 3);
    send(8'hAA); send(8'h04); send(8'h77);
    settle(30);
    chk(wr_n - bw == 0, "R10/R6 no write from dropped bytes", wr_n - bw, 0);
    chk(push_n - bp == 2, "R10 push count", push_n - bp, 2);
    if (push_n - bp >= 2)
      chk({push_log[bp+1], push_log[bp]} == 16'hC3A5, "R7 result order",
          {push_log[bp+1], push_log[bp]}, 16'hC3A5);
    chk(!alu_clk_en_o, "R5 gate off after result", alu_clk_en_o, 0);

    if (!done) begin
      done = 1;
      summary();
    end
  end
endmodule